// File: doc/BRIEF.md
# Prescaled Time Stamp Capture Unit

The block keeps a 16-bit free-running time counter that advances once per prescaler period. A 4-bit reload value sets the period. When a frame ends successfully, either a reception that has been stored or a completed transmission, the block takes the counter value from that cycle. It tags the value with the mailbox index and the direction, and offers it as a mailbox control-word write on a valid/ready stream. Frames that end in failure leave no stamp.

Captured stamps wait in a small ordered queue, and the queue head acts as the hold register. While the consumer holds `cap_ready` low, the head word, its index and its direction flag stay frozen, so the mailbox write sees a value that cannot move. An entry leaves the queue on a cycle where `cap_valid` and `cap_ready` are both high, and the next entry appears in the following cycle. When the queue has no room, new events are dropped and nothing is written for them.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset `tsc_value` is 0, `cap_valid` is 0 and the reload value is 0, so the counter advances on every clock edge.
- R2: The reload value is taken on a clock edge where `psc_wr_en` is high, and the counter does not advance on that edge. With reload N, the counter then advances by one on the N+1-th edge after the write and on every N+1 edges after that.
- R3: The counter wraps from 0xFFFF to 0x0000 and then keeps counting.
- R4: An edge with `rx_end` and `rx_good` both high queues a stamp equal to `tsc_value` in the cycle before that edge, with index `rx_idx` and `cap_is_tx` = 0. On an empty queue, `cap_valid` rises right after that edge.
- R5: An edge with `tx_end` and `tx_good` both high queues a stamp in the same way, with index `tx_idx` and `cap_is_tx` = 1.
- R6: An end strobe whose good bit is 0 queues nothing.
- R7: `cap_word` carries the stamp in bits 31:16, and bits 15:0 are zero.
- R8: While `cap_valid` is high and `cap_ready` is low, `cap_word`, `cap_idx` and `cap_is_tx` stay stable.
- R9: When good rx and tx ends fall on the same edge, both entries carry the same stamp, and the rx entry is presented first.
- R10: Entries leave in arrival order. The queue holds 4 entries and ignores events that find no room. If only one slot is free and both directions end on the same edge, the rx entry is kept and the tx entry is dropped.
- R11: A cycle with `cap_valid` and `cap_ready` both high removes the head entry. The next entry, or `cap_valid` = 0 when the queue is empty, shows after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psc_wr_en | input | 1 | Reload write strobe |
| psc_wr_data | input | 4 | Prescaler reload value N |
| tsc_value | output | 16 | Current counter value |
| rx_end | input | 1 | Reception finished strobe |
| rx_good | input | 1 | Reception was stored successfully |
| rx_idx | input | 5 | Mailbox index of the reception |
| tx_end | input | 1 | Transmission finished strobe |
| tx_good | input | 1 | Transmission succeeded |
| tx_idx | input | 5 | Mailbox index of the transmission |
| cap_valid | output | 1 | A stamp write is offered |
| cap_ready | input | 1 | Consumer takes the offered write |
| cap_word | output | 32 | Control word, stamp in bits 31:16 |
| cap_idx | output | 5 | Mailbox index to write |
| cap_is_tx | output | 1 | 1 for a transmit stamp, 0 for a receive stamp |

## Verification
The counter value moves on each clock edge where a tick falls. A write to the reload register shows its first advance N+1 edges later. A good end strobe on one edge shows up on the capture port directly after that edge, and a pop shows the next head directly after the popping edge. The bench drives every input at the falling edge, lets exactly one rising edge pass, and reads the results at the next falling edge. It computes each expected counter value as the start value plus the number of edges divided by N+1, and each expected stamp as the counter value it read before the strobe edge.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TS_W   = 16;
  localparam int unsigned PSC_W  = 4;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned QDEPTH = 4;

  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
  parameter int unsigned PSC_W = ts_pkg::PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PSC_W-1:0] wr_data,
  output logic             tick
);
  logic [PSC_W-1:0] reload_q;
  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (wr_en) begin
      reload_q <= wr_data;
      cnt_q    <= wr_data;
    end else if (cnt_q == '0) begin
      cnt_q <= reload_q;
    end else begin
      cnt_q <= cnt_q - PSC_W'(1);
    end
  end

  assign tick = (cnt_q == '0) && !wr_en;
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int unsigned TS_W = ts_pkg::TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [TS_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (tick) value <= value + TS_W'(1);
  end
endmodule

// File: rtl/ts_event_queue.sv
module ts_event_queue #(
  parameter int unsigned TS_W  = ts_pkg::TS_W,
  parameter int unsigned IDX_W = ts_pkg::IDX_W,
  parameter int unsigned DEPTH = ts_pkg::QDEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  stamp,
  input  logic             push_rx,
  input  logic [IDX_W-1:0] rx_idx,
  input  logic             push_tx,
  input  logic [IDX_W-1:0] tx_idx,
  input  logic             pop,
  output logic             head_valid,
  output logic [TS_W-1:0]  head_stamp,
  output logic [IDX_W-1:0] head_idx,
  output ts_pkg::dir_e     head_dir
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [TS_W-1:0]  stamp_q [DEPTH];
  logic [IDX_W-1:0] idx_q   [DEPTH];
  ts_pkg::dir_e     dir_q   [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, tx_ptr;
  logic [CNT_W-1:0] count, space;
  logic             take_rx, take_tx, do_pop;

  assign space   = CNT_W'(DEPTH) - count;
  assign take_rx = push_rx && (space != '0);
  assign take_tx = push_tx && (take_rx ? (space >= CNT_W'(2)) : (space != '0));
  assign do_pop  = pop && (count != '0);
  assign tx_ptr  = take_rx ? wr_ptr + PTR_W'(1) : wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stamp_q[i] <= '0;
        idx_q[i]   <= '0;
        dir_q[i]   <= ts_pkg::DIR_RX;
      end
    end else begin
      if (take_rx) begin
        stamp_q[wr_ptr] <= stamp;
        idx_q[wr_ptr]   <= rx_idx;
        dir_q[wr_ptr]   <= ts_pkg::DIR_RX;
      end
      if (take_tx) begin
        stamp_q[tx_ptr] <= stamp;
        idx_q[tx_ptr]   <= tx_idx;
        dir_q[tx_ptr]   <= ts_pkg::DIR_TX;
      end
      wr_ptr <= wr_ptr + PTR_W'(take_rx) + PTR_W'(take_tx);
      if (do_pop) rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + CNT_W'(take_rx) + CNT_W'(take_tx) - CNT_W'(do_pop);
    end
  end

  assign head_valid = (count != '0);
  assign head_stamp = stamp_q[rd_ptr];
  assign head_idx   = idx_q[rd_ptr];
  assign head_dir   = dir_q[rd_ptr];
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit #(
  parameter int unsigned TS_W   = ts_pkg::TS_W,
  parameter int unsigned PSC_W  = ts_pkg::PSC_W,
  parameter int unsigned IDX_W  = ts_pkg::IDX_W,
  parameter int unsigned WORD_W = ts_pkg::WORD_W,
  parameter int unsigned QDEPTH = ts_pkg::QDEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psc_wr_en,
  input  logic [PSC_W-1:0]  psc_wr_data,
  output logic [TS_W-1:0]   tsc_value,
  input  logic              rx_end,
  input  logic              rx_good,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic              tx_end,
  input  logic              tx_good,
  input  logic [IDX_W-1:0]  tx_idx,
  output logic              cap_valid,
  input  logic              cap_ready,
  output logic [WORD_W-1:0] cap_word,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              cap_is_tx
);
  localparam int unsigned STAMP_LSB = WORD_W - TS_W;

  logic            tick;
  logic [TS_W-1:0] head_stamp;
  ts_pkg::dir_e    head_dir;

  ts_prescaler #(.PSC_W(PSC_W)) psc_i (
    .clk(clk), .rst_n(rst_n), .wr_en(psc_wr_en), .wr_data(psc_wr_data), .tick(tick)
  );

  ts_counter #(.TS_W(TS_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .value(tsc_value)
  );

  ts_event_queue #(.TS_W(TS_W), .IDX_W(IDX_W), .DEPTH(QDEPTH)) q_i (
    .clk(clk), .rst_n(rst_n), .stamp(tsc_value),
    .push_rx(rx_end && rx_good), .rx_idx(rx_idx),
    .push_tx(tx_end && tx_good), .tx_idx(tx_idx),
    .pop(cap_ready),
    .head_valid(cap_valid), .head_stamp(head_stamp),
    .head_idx(cap_idx), .head_dir(head_dir)
  );

  assign cap_word  = WORD_W'(head_stamp) << STAMP_LSB;
  assign cap_is_tx = (head_dir == ts_pkg::DIR_TX);
endmodule

// File: rtl/ts_capture_checker.sv
module ts_capture_checker #(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_end,
  input logic              rx_good,
  input logic [IDX_W-1:0]  rx_idx,
  input logic              tx_end,
  input logic              tx_good,
  input logic [TS_W-1:0]   tsc_value,
  input logic              cap_valid,
  input logic              cap_ready,
  input logic [WORD_W-1:0] cap_word,
  input logic [IDX_W-1:0]  cap_idx,
  input logic              cap_is_tx
);
  // R2 / R3: the counter only ever holds or steps by one, wrap included
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tsc_value == $past(tsc_value)) || (tsc_value == $past(tsc_value) + TS_W'(1)));

  // R8: the held head does not move under back-pressure
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> cap_valid && $stable(cap_word) && $stable(cap_idx) && $stable(cap_is_tx));

  // R6: with no good end strobe, an empty queue stays empty
  a_r6_no_stamp_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid && !(rx_end && rx_good) && !(tx_end && tx_good)) |=> !cap_valid);

  // R4 / R7: a good rx end on an empty queue is presented right after the edge
  a_r4_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid && rx_end && rx_good) |=>
      cap_valid && !cap_is_tx && (cap_idx == $past(rx_idx)) &&
      (cap_word[WORD_W-1 -: TS_W] == $past(tsc_value)));
endmodule

bind ts_capture_unit ts_capture_checker #(.TS_W(TS_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_end(rx_end), .rx_good(rx_good), .rx_idx(rx_idx),
  .tx_end(tx_end), .tx_good(tx_good), .tsc_value(tsc_value), .cap_valid(cap_valid),
  .cap_ready(cap_ready), .cap_word(cap_word), .cap_idx(cap_idx), .cap_is_tx(cap_is_tx)
);

// File: tb/ts_capture_unit_tb.sv
module ts_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psc_wr_en = 1'b0;
  logic [3:0]  psc_wr_data = '0;
  logic [15:0] tsc_value;
  logic        rx_end = 1'b0, rx_good = 1'b0, tx_end = 1'b0, tx_good = 1'b0;
  logic [4:0]  rx_idx = '0, tx_idx = '0;
  logic        cap_valid, cap_ready = 1'b0, cap_is_tx;
  logic [31:0] cap_word;
  logic [4:0]  cap_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ts_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .psc_wr_en(psc_wr_en), .psc_wr_data(psc_wr_data),
    .tsc_value(tsc_value), .rx_end(rx_end), .rx_good(rx_good), .rx_idx(rx_idx),
    .tx_end(tx_end), .tx_good(tx_good), .tx_idx(tx_idx), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_word(cap_word), .cap_idx(cap_idx), .cap_is_tx(cap_is_tx)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reload(input int n);
    psc_wr_en = 1'b1; psc_wr_data = 4'(n);
    step();
    psc_wr_en = 1'b0;
  endtask

  // check the head entry, then pop it with one ready cycle
  task automatic expect_head(input string req, input logic [15:0] st, input int idx, input bit is_tx);
    chk(req, "cap_valid", cap_valid, 1);
    chk(req, "stamp", cap_word[31:16], st);
    chk("R7", "low half", cap_word[15:0], 0);
    chk(req, "idx", cap_idx, idx);
    chk(req, "is_tx", cap_is_tx, is_tx);
    cap_ready = 1'b1;
    step();
    cap_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] t0, s, st[5];
    int guard;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "tsc reset", tsc_value, 0);
    chk("R1", "cap_valid reset", cap_valid, 0);
    rst_n = 1'b1;
    step();
    chk("R1", "reload 0 steps each edge", tsc_value, 1);
    step();
    chk("R1", "reload 0 steps each edge", tsc_value, 2);

    // R2 sweep over every reload value
    for (int n = 0; n < 16; n++) begin
      t0 = tsc_value;
      write_reload(n);
      chk("R2", "no step on write edge", tsc_value, t0);
      t0 = tsc_value;
      for (int k = 1; k <= 40; k++) begin
        step();
        chk("R2", $sformatf("reload %0d after %0d edges", n, k), tsc_value, 16'(t0 + k / (n + 1)));
      end
    end

    // R3 wrap
    write_reload(0);
    guard = 0;
    while (tsc_value != 16'hFFFF && guard < 70000) begin step(); guard++; end
    chk("R3", "reached max", tsc_value, 16'hFFFF);
    step();
    chk("R3", "wrap to zero", tsc_value, 0);
    step();
    chk("R3", "counts after wrap", tsc_value, 1);

    // R6 failed ends leave nothing
    rx_end = 1'b1; rx_good = 1'b0; tx_end = 1'b1; tx_good = 1'b0; rx_idx = 5'd3; tx_idx = 5'd4;
    step();
    rx_end = 1'b0; tx_end = 1'b0;
    chk("R6", "no capture on failed ends", cap_valid, 0);
    step();
    chk("R6", "still empty", cap_valid, 0);

    // R4, R5, R7, R11: sweep every index in both directions, consumer ready
    cap_ready = 1'b1;
    for (int i = 0; i < 32; i++) begin
      s = tsc_value;
      rx_end = 1'b1; rx_good = 1'b1; rx_idx = 5'(i);
      step();
      rx_end = 1'b0; rx_good = 1'b0;
      chk("R4", "rx valid", cap_valid, 1);
      chk("R4", "rx stamp", cap_word[31:16], s);
      chk("R7", "low half", cap_word[15:0], 0);
      chk("R4", "rx idx", cap_idx, i);
      chk("R4", "rx dir", cap_is_tx, 0);
      step();
      chk("R11", "popped to empty", cap_valid, 0);
      s = tsc_value;
      tx_end = 1'b1; tx_good = 1'b1; tx_idx = 5'(31 - i);
      step();
      tx_end = 1'b0; tx_good = 1'b0;
      chk("R5", "tx valid", cap_valid, 1);
      chk("R5", "tx stamp", cap_word[31:16], s);
      chk("R5", "tx idx", cap_idx, 31 - i);
      chk("R5", "tx dir", cap_is_tx, 1);
      step();
      chk("R11", "popped to empty", cap_valid, 0);
    end
    cap_ready = 1'b0;

    // R9 and R8: simultaneous ends held under back-pressure
    s = tsc_value;
    rx_end = 1'b1; rx_good = 1'b1; rx_idx = 5'd9;
    tx_end = 1'b1; tx_good = 1'b1; tx_idx = 5'd17;
    step();
    rx_end = 1'b0; rx_good = 1'b0; tx_end = 1'b0; tx_good = 1'b0;
    repeat (5) step();
    chk("R8", "held stamp", cap_word[31:16], s);
    chk("R8", "held idx", cap_idx, 9);
    expect_head("R9", s, 9, 0);
    expect_head("R9", s, 17, 1);
    chk("R11", "empty after drain", cap_valid, 0);

    // R10 order, capacity and drop of tx when one slot is left
    for (int e = 0; e < 4; e++) begin
      st[e] = tsc_value;
      if (e == 1) begin tx_end = 1'b1; tx_good = 1'b1; tx_idx = 5'(e + 1); end
      else begin rx_end = 1'b1; rx_good = 1'b1; rx_idx = 5'(e + 1); end
      if (e == 3) begin tx_end = 1'b1; tx_good = 1'b1; tx_idx = 5'd5; end
      step();
      rx_end = 1'b0; rx_good = 1'b0; tx_end = 1'b0; tx_good = 1'b0;
    end
    rx_end = 1'b1; rx_good = 1'b1; rx_idx = 5'd20;
    step();
    rx_end = 1'b0; rx_good = 1'b0;
    expect_head("R10", st[0], 1, 0);
    expect_head("R10", st[1], 2, 1);
    expect_head("R10", st[2], 3, 0);
    expect_head("R10", st[3], 4, 0);
    chk("R10", "dropped events absent", cap_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule